// File: doc/BRIEF.md
# Banked Stack Pointer Control Registers

This block holds a processor's small set of control registers: a packed status word, a separate view of the condition flag, two stack pointers, and three plain storage words. One stack pointer is always live in general register R15, which the block owns and offers to the rest of the register file through a side port. The other stack pointer waits in a shadow register. When software rewrites the status word and flips the stack-mode bit, the live pointer is put away and the other one is brought into R15 on the same clock edge.

Control registers are addressed by a small index on one read port and one write port. Reads are registered: the data for an index presented in one cycle appears on the following cycle and shows the state from before any write on that same edge. An index beyond the last implemented register reads as zero and cannot be written.

Top module: `csr_spbank`

## Requirements
- R1: Index 0 reads the status word with stack mode backup at bit 15, interrupt-enable backup at bit 14, condition backup at bit 8, stack mode at bit 7, interrupt enable at bit 6 and condition at bit 0; all other bits read 0. A write to index 0 loads those six bits from the same positions of the written value.
- R2: Index 1 reads the condition bit at bit 0 with zeros elsewhere; a write to index 1 changes only the condition bit, from bit 0 of the written value.
- R3: Index 2 (interrupt stack pointer) reads and writes R15 while stack mode is 0, and its shadow register while stack mode is 1.
- R4: Index 3 (user stack pointer) reads and writes R15 while stack mode is 1, and its shadow register while stack mode is 0.
- R5: A status write that moves stack mode from 0 to 1 stores R15 into the index-2 shadow and loads R15 from the index-3 shadow.
- R6: A status write that moves stack mode from 1 to 0 stores R15 into the index-3 shadow and loads R15 from the index-2 shadow.
- R7: Indices 4, 5 and 6 are full-width storage words that read back the last value written.
- R8: A read of any index above 6 returns 0, and a write to such an index changes no register.
- R9: A status write that keeps stack mode unchanged moves neither R15 nor either shadow.
- R10: Read data appears one cycle after the index is presented and reflects the state before a write on that same edge; a swap or write to R15 is visible on the R15 output on the cycle after the write.
- R11: Synchronous active-high reset clears all status bits, R15, both shadows and the storage words, and the read output.
- R12: The side port writes R15 when no control-register write targets R15 in the same cycle; a control write that targets R15 (index 2 or 3 routed to R15, or a swap) takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | IW | Control register index to read |
| rd_data | output | DW | Registered read data, one cycle after rd_idx |
| wr_en | input | 1 | Control register write strobe |
| wr_idx | input | IW | Control register index to write |
| wr_data | input | DW | Control register write data |
| r15_we | input | 1 | Side-port write strobe for R15 |
| r15_wdata | input | DW | Side-port write data for R15 |
| r15_q | output | DW | Current R15 contents |

## Verification
The bench builds the block with its defaults: 32-bit data, a 4-bit index and three storage words, so indices 7 to 15 exist on the port but name no register, which puts the zero-read and ignored-write behaviour within reach. The behavioural model walks both mode transitions with distinct pointer values so a swapped or crossed shadow shows at once, and it collides side-port and control writes on R15 to exercise their priority. Same-edge read-and-write pairs confirm that reads report pre-write state.

// File: rtl/csr_spbank_pkg.sv
package csr_spbank_pkg;

  localparam int SW_W      = 16;
  localparam int BSM_BIT   = 15;
  localparam int BIE_BIT   = 14;
  localparam int BCOND_BIT = 8;
  localparam int SM_BIT    = 7;
  localparam int IE_BIT    = 6;
  localparam int COND_BIT  = 0;

  localparam int IDX_STATUS = 0;
  localparam int IDX_COND   = 1;
  localparam int IDX_ISP    = 2;
  localparam int IDX_USP    = 3;
  localparam int IDX_STORE0 = 4;

  typedef struct packed {
    logic bsm;
    logic bie;
    logic bcond;
    logic sm;
    logic ie;
    logic cond;
  } status_t;

  function automatic logic [SW_W-1:0] pack_status(input status_t s);
    logic [SW_W-1:0] w;
    w            = '0;
    w[BSM_BIT]   = s.bsm;
    w[BIE_BIT]   = s.bie;
    w[BCOND_BIT] = s.bcond;
    w[SM_BIT]    = s.sm;
    w[IE_BIT]    = s.ie;
    w[COND_BIT]  = s.cond;
    return w;
  endfunction

  function automatic status_t unpack_status(input logic [SW_W-1:0] w);
    status_t s;
    s.bsm   = w[BSM_BIT];
    s.bie   = w[BIE_BIT];
    s.bcond = w[BCOND_BIT];
    s.sm    = w[SM_BIT];
    s.ie    = w[IE_BIT];
    s.cond  = w[COND_BIT];
    return s;
  endfunction

endpackage

// File: rtl/csr_status.sv
module csr_status
  import csr_spbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            psw_we,
  input  logic            cond_we,
  input  logic [SW_W-1:0] wfield,
  output status_t         st_q,
  output logic            mode_flip
);

  status_t st_new;

  always_comb begin
    st_new    = unpack_status(wfield);
    mode_flip = psw_we && (st_new.sm != st_q.sm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (psw_we) begin
      st_q <= st_new;
    end else if (cond_we) begin
      st_q.cond <= wfield[COND_BIT];
    end
  end

endmodule

// File: rtl/csr_stack_bank.sv
module csr_stack_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sm,
  input  logic          mode_flip,
  input  logic          isp_we,
  input  logic          usp_we,
  input  logic [DW-1:0] wdata,
  input  logic          side_we,
  input  logic [DW-1:0] side_wdata,
  output logic [DW-1:0] r15_q,
  output logic [DW-1:0] sh_isp_q,
  output logic [DW-1:0] sh_usp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      r15_q    <= '0;
      sh_isp_q <= '0;
      sh_usp_q <= '0;
    end else begin
      if (side_we) r15_q <= side_wdata;
      if (mode_flip) begin
        if (!sm) begin
          sh_isp_q <= r15_q;
          r15_q    <= sh_usp_q;
        end else begin
          sh_usp_q <= r15_q;
          r15_q    <= sh_isp_q;
        end
      end else if (isp_we) begin
        if (!sm) r15_q    <= wdata;
        else     sh_isp_q <= wdata;
      end else if (usp_we) begin
        if (sm)  r15_q    <= wdata;
        else     sh_usp_q <= wdata;
      end
    end
  end

endmodule

// File: rtl/csr_store_bank.sv
module csr_store_bank #(
  parameter int DW     = 32,
  parameter int NSTORE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTORE-1:0] we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_word [NSTORE]
);

  for (genvar g = 0; g < NSTORE; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)        word_q <= '0;
      else if (we[g]) word_q <= wdata;
    end
    assign rd_word[g] = word_q;
  end

endmodule

// File: rtl/csr_spbank.sv
module csr_spbank
  import csr_spbank_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IW     = 4,
  parameter int NSTORE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          r15_we,
  input  logic [DW-1:0] r15_wdata,
  output logic [DW-1:0] r15_q
);

  localparam int LAST_IDX = IDX_STORE0 + NSTORE - 1;

  status_t       st_q;
  logic          mode_flip;
  logic          psw_we, cond_we, isp_we, usp_we;
  logic [NSTORE-1:0] store_we;
  logic [DW-1:0] sh_isp_q, sh_usp_q;
  logic [DW-1:0] store_rd [NSTORE];
  logic [DW-1:0] rd_next;

  always_comb begin
    psw_we  = wr_en && (int'(wr_idx) == IDX_STATUS);
    cond_we = wr_en && (int'(wr_idx) == IDX_COND);
    isp_we  = wr_en && (int'(wr_idx) == IDX_ISP);
    usp_we  = wr_en && (int'(wr_idx) == IDX_USP);
    for (int k = 0; k < NSTORE; k++)
      store_we[k] = wr_en && (int'(wr_idx) == IDX_STORE0 + k);
  end

  csr_status u_status (
    .clk       (clk),
    .rst       (rst),
    .psw_we    (psw_we),
    .cond_we   (cond_we),
    .wfield    (wr_data[SW_W-1:0]),
    .st_q      (st_q),
    .mode_flip (mode_flip)
  );

  csr_stack_bank #(.DW(DW)) u_stack (
    .clk        (clk),
    .rst        (rst),
    .sm         (st_q.sm),
    .mode_flip  (mode_flip),
    .isp_we     (isp_we),
    .usp_we     (usp_we),
    .wdata      (wr_data),
    .side_we    (r15_we),
    .side_wdata (r15_wdata),
    .r15_q      (r15_q),
    .sh_isp_q   (sh_isp_q),
    .sh_usp_q   (sh_usp_q)
  );

  csr_store_bank #(.DW(DW), .NSTORE(NSTORE)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (store_we),
    .wdata   (wr_data),
    .rd_word (store_rd)
  );

  always_comb begin
    rd_next = '0;
    case (int'(rd_idx))
      IDX_STATUS: rd_next[SW_W-1:0] = pack_status(st_q);
      IDX_COND:   rd_next[0]        = st_q.cond;
      IDX_ISP:    rd_next           = st_q.sm ? sh_isp_q : r15_q;
      IDX_USP:    rd_next           = st_q.sm ? r15_q : sh_usp_q;
      default: begin
        for (int k = 0; k < NSTORE; k++)
          if (int'(rd_idx) == IDX_STORE0 + k) rd_next = store_rd[k];
        if (int'(rd_idx) > LAST_IDX) rd_next = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/csr_spbank_chk.sv
module csr_spbank_chk #(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] rd_idx,
  input logic [DW-1:0] rd_data,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          r15_we,
  input logic [DW-1:0] r15_wdata,
  input logic [DW-1:0] r15_q,
  input logic [DW-1:0] sh_isp,
  input logic [DW-1:0] sh_usp,
  input logic          sm
);

  logic psw_toggle;
  assign psw_toggle = wr_en && (wr_idx == '0) && (wr_data[7] != sm);

  assert_swap_up_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(psw_toggle) && !$past(sm) |->
      (r15_q == $past(sh_usp)) && (sh_isp == $past(r15_q)));

  assert_swap_down_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(psw_toggle) && $past(sm) |->
      (r15_q == $past(sh_isp)) && (sh_usp == $past(r15_q)));

  assert_unknown_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_idx) > 6) |=> (rd_data == '0));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |=> ((rd_data & ~DW'(32'h0000_C1C1)) == '0));

  assert_psw_keep_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_idx == '0) && (wr_data[7] == sm) |=>
      $stable(sh_isp) && $stable(sh_usp));

  assert_isp_direct_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && (int'(wr_idx) == 2) && !sm |=> (r15_q == $past(wr_data)));

  assert_side_write_R12: assert property (@(posedge clk) disable iff (rst)
    r15_we && !wr_en |=> (r15_q == $past(r15_wdata)));

  assert_reset_R11: assert property (@(posedge clk)
    $past(rst) |-> (r15_q == '0) && (sh_isp == '0) && (sh_usp == '0) && !sm && (rd_data == '0));

endmodule

bind csr_spbank csr_spbank_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .r15_we    (r15_we),
  .r15_wdata (r15_wdata),
  .r15_q     (r15_q),
  .sh_isp    (sh_isp_q),
  .sh_usp    (sh_usp_q),
  .sm        (st_q.sm)
);

// File: tb/csr_spbank_bench.sv
module csr_spbank_bench;

  localparam int DW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic          r15_we;
  logic [DW-1:0] r15_wdata;
  logic [DW-1:0] r15_q;

  csr_spbank #(.DW(DW), .IW(IW), .NSTORE(3)) u_csr_spbank (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .r15_we(r15_we), .r15_wdata(r15_wdata), .r15_q(r15_q)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  bit        m_bsm, m_bie, m_bcond, m_sm, m_ie, m_cond;
  bit [31:0] m_r15, m_isp, m_usp;
  bit [31:0] m_store [3];
  bit [31:0] exp_rd;
  int        checks = 0;
  int        errors = 0;
  string     cur_req = "R11";
  bit        done = 0;

  function automatic bit [31:0] mread(int idx);
    bit [31:0] v = 0;
    case (idx)
      0: v = {16'd0, m_bsm, m_bie, 5'd0, m_bcond, m_sm, m_ie, 5'd0, m_cond};
      1: v = {31'd0, m_cond};
      2: v = m_sm ? m_isp : m_r15;
      3: v = m_sm ? m_r15 : m_usp;
      4, 5, 6: v = m_store[idx-4];
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_edge();
    int wi;
    bit [31:0] d;
    bit newsm;
    if (rst) begin
      {m_bsm, m_bie, m_bcond, m_sm, m_ie, m_cond} = '0;
      m_r15 = 0; m_isp = 0; m_usp = 0;
      foreach (m_store[i]) m_store[i] = 0;
      exp_rd = 0;
      return;
    end
    exp_rd = mread(int'(rd_idx));
    if (r15_we) m_r15 = r15_wdata;
    if (!wr_en) return;
    wi = int'(wr_idx);
    d  = wr_data;
    if (wi == 0) begin
      newsm = d[7];
      if (newsm && !m_sm) begin
        m_isp = m_r15; m_r15 = m_usp;
      end else if (!newsm && m_sm) begin
        m_usp = m_r15; m_r15 = m_isp;
      end
      m_bsm = d[15]; m_bie = d[14]; m_bcond = d[8];
      m_sm = d[7]; m_ie = d[6]; m_cond = d[0];
    end else if (wi == 1) m_cond = d[0];
    else if (wi == 2) begin
      if (m_sm) m_isp = d; else m_r15 = d;
    end else if (wi == 3) begin
      if (m_sm) m_r15 = d; else m_usp = d;
    end else if (wi >= 4 && wi <= 6) m_store[wi-4] = d;
  endtask

  task automatic check(string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", cur_req, what, act, exp);
    end
  endtask

  // one clock: inputs held, model stepped after the edge, compared at negedge
  task automatic op(bit we, int widx, bit [31:0] wd, int ridx,
                    bit swe = 0, bit [31:0] swd = 0);
    wr_en = we; wr_idx = IW'(widx); wr_data = wd;
    rd_idx = IW'(ridx); r15_we = swe; r15_wdata = swd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("rd_data", rd_data, exp_rd);
    check("r15_q", r15_q, m_r15);
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0;
    r15_we = 0; r15_wdata = 0;
    @(negedge clk);
    cur_req = "R11";
    op(0, 0, 0, 0);
    op(0, 0, 0, 0);
    rst = 0;
    for (int i = 0; i < 8; i++) op(0, 0, 0, i);

    cur_req = "R12";
    op(0, 0, 0, 0, 1, 32'hAAAA_0001);
    cur_req = "R3";
    op(1, 2, 32'h1111_2222, 2);
    op(0, 0, 0, 2);
    cur_req = "R4";
    op(1, 3, 32'h3333_4444, 3);
    op(0, 0, 0, 3);
    cur_req = "R10";
    op(1, 3, 32'h5555_6666, 3);
    op(0, 0, 0, 3);

    cur_req = "R5";
    op(1, 0, 32'hFFFF_FFFF, 2);
    op(0, 0, 0, 0);
    op(0, 0, 0, 2);
    op(0, 0, 0, 3);
    cur_req = "R1";
    op(0, 0, 0, 0);

    cur_req = "R2";
    op(1, 1, 32'hFFFF_FFFE, 1);
    op(0, 0, 0, 1);
    op(0, 0, 0, 0);
    op(1, 1, 32'h0000_0001, 1);
    op(0, 0, 0, 1);

    cur_req = "R9";
    op(1, 0, 32'h0000_0080, 0);
    op(0, 0, 0, 2);
    op(0, 0, 0, 3);

    cur_req = "R3";
    op(1, 2, 32'h7777_8888, 2);
    op(0, 0, 0, 2);
    cur_req = "R4";
    op(1, 3, 32'h9999_AAAA, 3);
    op(0, 0, 0, 3);

    cur_req = "R12";
    op(1, 3, 32'hBBBB_CCCC, 3, 1, 32'hDEAD_BEEF);
    op(0, 0, 0, 3, 1, 32'h0BAD_F00D);
    op(1, 2, 32'h0101_0101, 2, 1, 32'h0202_0202);

    cur_req = "R6";
    op(1, 0, 32'h0000_4101, 0);
    op(0, 0, 0, 2);
    op(0, 0, 0, 3);
    op(0, 0, 0, 0);
    cur_req = "R9";
    op(1, 0, 32'h0000_0040, 2);
    op(0, 0, 0, 3);

    cur_req = "R12";
    op(1, 2, 32'hCAFE_0002, 2, 1, 32'hFACE_0003);
    op(0, 0, 0, 2);

    cur_req = "R7";
    op(1, 4, 32'h4444_0004, 4);
    op(1, 5, 32'h5555_0005, 5);
    op(1, 6, 32'h6666_0006, 6);
    for (int i = 4; i < 7; i++) op(0, 0, 0, i);

    cur_req = "R8";
    op(1, 7, 32'hFFFF_FFFF, 7);
    op(1, 15, 32'h1234_5678, 15);
    for (int i = 0; i < 16; i++) op(0, 0, 0, i);

    cur_req = "R5";
    op(1, 0, 32'h0000_0080, 3);
    op(0, 0, 0, 2);
    cur_req = "R6";
    op(1, 0, 32'h0000_0000, 3);
    op(0, 0, 0, 2);

    cur_req = "R11";
    rst = 1;
    op(1, 4, 32'hFFFF_FFFF, 4, 1, 32'h1);
    rst = 0;
    for (int i = 0; i < 7; i++) op(0, 0, 0, i);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule